// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block is a half-duplex SPI host that runs one serial-flash command per trigger. Software prepares the command through a byte-wide register port. It writes an 8-bit command code, a count of bytes to send, a count of bytes to receive, the chip-select number, and the outgoing bytes in a shared byte buffer. It then sets the start bit. The engine drives the selected chip select low and clocks out the command code. It then clocks out the counted transmit bytes taken from the buffer, and clocks in the requested receive bytes. Each received byte is written back into the same buffer, in the slots that follow the last transmitted byte.

The buffer is walked by an internal byte pointer. The pointer is not rewound at the start of a frame; software rewinds it by writing a clear bit. By convention software places a multi-byte flash address with its most significant byte at the lowest buffer slot, and writes any dummy bytes as 0xFF counted as transmit bytes. The engine treats these as ordinary transmit bytes. A busy flag is set for the whole frame.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, busy reads 0, every chip select is high (inactive), the serial clock is low, and the buffer pointer is 0.
- R2: A frame is the command code (register 0x45), then the transmit bytes, then the receive bytes, each MSB first. The command code is not part of the transmit count (0x48). The frame gives exactly 8*(1+tx+rx) rising serial clock edges.
- R3: SPI mode 0 is used. The serial clock idles low. Data out changes only while the serial clock is low. Data in is sampled on the rising edge.
- R4: Transmit bytes come from consecutive buffer slots, starting at the current pointer. The pointer advances by one per transmitted or received byte and wraps after the last slot.
- R5: Received bytes (count in register 0x4B) are stored in the buffer slots that follow the last transmit slot, first received byte first.
- R6: Writing a byte with bit 7 set to address 0x47 starts a frame. Busy is bit 7 of address 0x4F, which is bit 31 of the 32-bit status word at 0x4C. Busy reads 1 from the trigger edge for HALF_DIV*(16*(1+tx+rx)+1) clock cycles.
- R7: Bits [1:0] of address 0x1D select the chip select. The selected chip select alone is low for the whole frame, including the command code. All chip selects are high between frames.
- R8: While busy, a trigger and every register or buffer write are ignored. The frame runs once, and the stored settings are unchanged afterwards.
- R9: With both counts zero, a frame sends only the command code: 8 clock pulses, and no buffer change.
- R10: Writing a byte with bit 4 set to address 0x02 (bit 20 of control word 0) sets the pointer to 0. Without it, the next frame continues from where the last one left the pointer.
- R11: The buffer holds BUF_DEPTH (70) bytes at addresses 0x80 upward, and can be read and written through the port when idle. Reads of addresses past its end return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Byte write strobe for the register port |
| regAddr | input | 8 | Byte address for reads and writes |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for regAddr (combinational) |
| sclk | output | 1 | Serial clock |
| csN | output | NUM_CS | Active-low chip selects |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |

## Verification
A flash model in the bench captures every bit on rising clock edges, drives reply bits after falling edges, and is compared with byte queues built from the requirements. The bench targets these corner cases:
- A receive-only frame. A design that stored replies from slot zero instead of after the transmit bytes would overwrite outgoing data.
- A frame with both counts zero. A wrong design would emit stray bytes or hang.
- A trigger and an opcode write landing mid-frame. A wrong design would restart or change the command.
- Back-to-back frames with and without a pointer clear. A design that rewound the pointer on every trigger, or ignored the clear, would send the wrong buffer slot.
- Chip-select decode and busy length, checked on every clock. These expose a design that drops the select before the last bit or holds busy one half-period short.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam logic [7:0] ADR_CTRL_B2 = 8'h02;
  localparam logic [7:0] ADR_CSSEL   = 8'h1D;
  localparam logic [7:0] ADR_OPCODE  = 8'h45;
  localparam logic [7:0] ADR_TRIG    = 8'h47;
  localparam logic [7:0] ADR_TXCNT   = 8'h48;
  localparam logic [7:0] ADR_RXCNT   = 8'h4B;
  localparam logic [7:0] ADR_STAT_B3 = 8'h4F;
  localparam logic [7:0] ADR_BUF     = 8'h80;

  typedef enum logic [1:0] {ST_IDLE, ST_SCK_LO, ST_SCK_HI, ST_TAIL} seqState_e;
  typedef enum logic [1:0] {PH_OPC, PH_TX, PH_RX} seqPhase_e;

  typedef struct packed {
    logic loadOpc;
    logic shiftTx;
    logic sampleRx;
    logic advPtr;
    logic storeRx;
    logic loadBuf;
    logic loadZero;
  } seqStb_t;
endpackage

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
#(
  parameter int BUF_DEPTH = 70,
  parameter int CS_W      = 2,
  localparam int PTR_W    = $clog2(BUF_DEPTH)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            regWrEn,
  input  logic [7:0]      regAddr,
  input  logic [7:0]      regWrData,
  output logic [7:0]      regRdData,
  input  logic            busy,
  input  seqStb_t         stb,
  input  logic            miso,
  output logic            mosi,
  output logic            trigReq,
  output logic [7:0]      txCount,
  output logic [7:0]      rxCount,
  output logic [CS_W-1:0] csSel
);
  localparam logic [7:0]       DEPTH8 = 8'(BUF_DEPTH);
  localparam logic [PTR_W-1:0] LAST   = PTR_W'(BUF_DEPTH - 1);

  logic [7:0]       opcReg;
  logic [7:0]       txShift;
  logic [7:0]       rxShift;
  logic [PTR_W-1:0] ptr;
  logic [PTR_W-1:0] ptrNext;
  logic [7:0]       bufMem [BUF_DEPTH];
  logic [7:0]       bufOff;
  logic             inBuf;
  logic             wrOk;
  logic             clrReq;

  assign wrOk    = regWrEn && !busy;
  assign bufOff  = regAddr - ADR_BUF;
  assign inBuf   = (regAddr >= ADR_BUF) && (bufOff < DEPTH8);
  assign trigReq = wrOk && (regAddr == ADR_TRIG) && regWrData[7];
  assign clrReq  = wrOk && (regAddr == ADR_CTRL_B2) && regWrData[4];
  assign ptrNext = stb.advPtr ? ((ptr == LAST) ? '0 : ptr + PTR_W'(1)) : ptr;
  assign mosi    = txShift[7];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opcReg  <= '0;
      txCount <= '0;
      rxCount <= '0;
      csSel   <= '0;
      ptr     <= '0;
      txShift <= '0;
      rxShift <= '0;
      for (int i = 0; i < BUF_DEPTH; i++) bufMem[i] <= '0;
    end else begin
      if (wrOk) begin
        if (regAddr == ADR_OPCODE) opcReg  <= regWrData;
        if (regAddr == ADR_TXCNT)  txCount <= regWrData;
        if (regAddr == ADR_RXCNT)  rxCount <= regWrData;
        if (regAddr == ADR_CSSEL)  csSel   <= regWrData[CS_W-1:0];
        if (inBuf) bufMem[bufOff[PTR_W-1:0]] <= regWrData;
      end
      if (stb.storeRx) bufMem[ptr] <= rxShift;
      if (clrReq) ptr <= '0;
      else if (stb.advPtr) ptr <= ptrNext;
      if (stb.loadOpc)       txShift <= opcReg;
      else if (stb.loadBuf)  txShift <= bufMem[ptrNext];
      else if (stb.loadZero) txShift <= '0;
      else if (stb.shiftTx)  txShift <= {txShift[6:0], 1'b0};
      if (stb.sampleRx) rxShift <= {rxShift[6:0], miso};
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADR_OPCODE:  regRdData = opcReg;
      ADR_TXCNT:   regRdData = txCount;
      ADR_RXCNT:   regRdData = rxCount;
      ADR_CSSEL:   regRdData = 8'(csSel);
      ADR_STAT_B3: regRdData = {busy, 7'b0};
      default:     if (inBuf) regRdData = bufMem[bufOff[PTR_W-1:0]];
    endcase
  end

  p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> ($stable(opcReg) && $stable(txCount) &&
                               $stable(rxCount) && $stable(csSel)));

  p_ptr_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !busy && regAddr == ADR_CTRL_B2 && regWrData[4]) |=> (ptr == '0));

  p_store_needs_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.storeRx |-> (busy && stb.advPtr));
endmodule

// File: rtl/seq_control.sv
module seq_control
  import seq_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int NUM_CS   = 4,
  localparam int CS_W    = $clog2(NUM_CS),
  localparam int DIV_W   = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              trigReq,
  input  logic [7:0]        txCount,
  input  logic [7:0]        rxCount,
  input  logic [CS_W-1:0]   csSel,
  output seqStb_t           stb,
  output logic              busy,
  output logic              sclk,
  output logic [NUM_CS-1:0] csN
);
  localparam logic [DIV_W-1:0] DIV_MAX = DIV_W'(HALF_DIV - 1);

  seqState_e        state;
  seqPhase_e        phase;
  logic [2:0]       bitCnt;
  logic [7:0]       txLeft;
  logic [7:0]       rxLeft;
  logic [7:0]       txRemain;
  logic [7:0]       rxRemain;
  logic [DIV_W-1:0] divCnt;
  logic             tick;
  logic             byteEnd;

  assign busy     = (state != ST_IDLE);
  assign sclk     = (state == ST_SCK_HI);
  assign tick     = busy && (divCnt == DIV_MAX);
  assign byteEnd  = (state == ST_SCK_HI) && tick && (bitCnt == 3'd7);
  assign txRemain = (phase == PH_TX) ? txLeft - 8'd1 : txLeft;
  assign rxRemain = (phase == PH_RX) ? rxLeft - 8'd1 : rxLeft;

  generate
    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
      assign csN[g] = !(busy && (csSel == CS_W'(g)));
    end
  endgenerate

  always_comb begin
    stb = '0;
    stb.loadOpc  = (state == ST_IDLE) && trigReq;
    stb.sampleRx = (state == ST_SCK_LO) && tick;
    stb.shiftTx  = (state == ST_SCK_HI) && tick && (bitCnt != 3'd7);
    if (byteEnd) begin
      stb.advPtr   = (phase != PH_OPC);
      stb.storeRx  = (phase == PH_RX);
      stb.loadBuf  = (txRemain != 8'd0);
      stb.loadZero = (txRemain == 8'd0) && (rxRemain != 8'd0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      phase  <= PH_OPC;
      bitCnt <= '0;
      txLeft <= '0;
      rxLeft <= '0;
      divCnt <= '0;
    end else begin
      if (busy) divCnt <= tick ? '0 : divCnt + DIV_W'(1);
      case (state)
        ST_IDLE: if (trigReq) begin
          state  <= ST_SCK_LO;
          phase  <= PH_OPC;
          bitCnt <= '0;
          txLeft <= txCount;
          rxLeft <= rxCount;
          divCnt <= '0;
        end
        ST_SCK_LO: if (tick) state <= ST_SCK_HI;
        ST_SCK_HI: if (tick) begin
          if (bitCnt != 3'd7) begin
            bitCnt <= bitCnt + 3'd1;
            state  <= ST_SCK_LO;
          end else begin
            bitCnt <= '0;
            txLeft <= txRemain;
            rxLeft <= rxRemain;
            if (txRemain != 8'd0) begin
              phase <= PH_TX;
              state <= ST_SCK_LO;
            end else if (rxRemain != 8'd0) begin
              phase <= PH_RX;
              state <= ST_SCK_LO;
            end else begin
              state <= ST_TAIL;
            end
          end
        end
        ST_TAIL: if (tick) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_start_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && trigReq) |=> (busy && !sclk));

  p_one_select_r7: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> ($countones(~csN) == 1));

  p_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (&csN));

  p_tx_before_rx_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busy && phase == PH_RX) |-> (txLeft == 8'd0));
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import seq_pkg::*;
#(
  parameter int BUF_DEPTH = 70,
  parameter int HALF_DIV  = 2,
  parameter int NUM_CS    = 4,
  localparam int CS_W     = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [7:0]        regAddr,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  output logic              sclk,
  output logic [NUM_CS-1:0] csN,
  output logic              mosi,
  input  logic              miso
);
  seqStb_t         stb;
  logic            busy;
  logic            trigReq;
  logic [7:0]      txCount;
  logic [7:0]      rxCount;
  logic [CS_W-1:0] csSel;

  seq_datapath #(.BUF_DEPTH(BUF_DEPTH), .CS_W(CS_W)) u_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .busy(busy), .stb(stb),
    .miso(miso), .mosi(mosi), .trigReq(trigReq), .txCount(txCount),
    .rxCount(rxCount), .csSel(csSel)
  );

  seq_control #(.HALF_DIV(HALF_DIV), .NUM_CS(NUM_CS)) u_ctl (
    .clk(clk), .rstN(rstN), .trigReq(trigReq), .txCount(txCount),
    .rxCount(rxCount), .csSel(csSel), .stb(stb), .busy(busy),
    .sclk(sclk), .csN(csN)
  );

  p_mosi_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (sclk && $past(sclk)) |-> $stable(mosi));

  p_idle_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    (&csN) |-> !sclk);
endmodule

// File: tb/flash_cmd_seq_bench.sv
module flash_cmd_seq_bench;
  localparam int H     = 2;
  localparam int DEPTH = 70;

  logic       clk = 0;
  logic       rstN = 0;
  logic       regWrEn = 0;
  logic [7:0] regAddr = 0;
  logic [7:0] regWrData = 0;
  logic [7:0] regRdData;
  logic       sclk;
  logic [3:0] csN;
  logic       mosi;
  logic       miso;

  flash_cmd_seq u_flash_cmd_seq (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .sclk(sclk), .csN(csN),
    .mosi(mosi), .miso(miso)
  );

  always #10 clk = ~clk;

  int total = 0;
  int failed = 0;
  bit done = 0;

  logic [7:0] bufModel [DEPTH];
  int  ptrModel = 0;
  int  curCs = 0;
  bit  inFrame = 0;
  int  busyCycles = 0;
  int  riseCnt = 0;
  int  fallCnt = 0;
  int  respStart = 0;
  int  nResp = 0;
  logic [7:0] resp [8];
  bit  mosiBits [$];
  logic [7:0] expBytes [$];

  task automatic chk(input string req, input int act, input int exp, input string what);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic wrBuf(input int idx, input logic [7:0] d);
    wr(8'h80 + 8'(idx), d);
    bufModel[idx] = d;
  endtask

  task automatic clearPtr();
    wr(8'h02, 8'h10);
    ptrModel = 0;
  endtask

  // flash model: sample on rising edge, drive after falling edge
  always @(posedge sclk) begin
    mosiBits.push_back(mosi);
    riseCnt++;
  end
  always @(negedge sclk) fallCnt++;
  always @* begin
    int k;
    k = fallCnt - respStart;
    if (k >= 0 && k < 8 * nResp) miso = resp[k / 8][7 - (k % 8)];
    else miso = 1'b0;
  end

  // per-clock monitor of select, clock and busy window
  always @(negedge clk) begin
    if (inFrame && !csN[curCs]) busyCycles++;
    if (!(&csN)) begin
      if (csN !== ~(4'b1 << curCs)) begin
        total++; failed++;
        $display("FAIL R7 select: actual %0h expected %0h", csN, ~(4'b1 << curCs));
      end
    end else if (rstN && sclk !== 1'b0) begin
      total++; failed++;
      $display("FAIL R3 idle clock: actual %0h expected 0", sclk);
    end
  end

  task automatic startFrame(input logic [7:0] opc, input int cs, input int tx,
                            input int rx, input logic [7:0] r [8]);
    logic [7:0] st;
    wr(8'h45, opc);
    wr(8'h48, 8'(tx));
    wr(8'h4B, 8'(rx));
    wr(8'h1D, 8'(cs));
    curCs = cs;
    mosiBits.delete();
    expBytes.delete();
    expBytes.push_back(opc);
    for (int i = 0; i < tx; i++) expBytes.push_back(bufModel[(ptrModel + i) % DEPTH]);
    for (int i = 0; i < 8; i++) resp[i] = r[i];
    nResp = rx;
    respStart = 8 * (1 + tx);
    riseCnt = 0; fallCnt = 0; busyCycles = 0;
    inFrame = 1;
    wr(8'h47, 8'h80);
    rd(8'h4F, st);
    chk("R6", st[7], 1, "busy bit after trigger");
  endtask

  task automatic finishFrame(input int tx, input int rx, input string req);
    logic [7:0] got;
    logic [7:0] st;
    while (!(&csN)) @(negedge clk);
    inFrame = 0;
    chk("R2", riseCnt, 8 * (1 + tx + rx), {req, " clock count"});
    chk("R6", busyCycles, H * (16 * (1 + tx + rx) + 1), {req, " busy length"});
    rd(8'h4F, st);
    chk("R6", st[7], 0, {req, " busy clear"});
    for (int b = 0; b < 1 + tx; b++) begin
      got = '0;
      for (int i = 0; i < 8; i++)
        if (8 * b + i < mosiBits.size()) got = {got[6:0], mosiBits[8 * b + i]};
      chk((b == 0) ? "R2" : "R4", got, expBytes[b], {req, " sent byte"});
    end
    for (int i = 0; i < rx; i++) begin
      int idx = (ptrModel + tx + i) % DEPTH;
      bufModel[idx] = resp[i];
      rd(8'h80 + 8'(idx), got);
      chk("R5", got, resp[i], {req, " stored reply"});
    end
    ptrModel = (ptrModel + tx + rx) % DEPTH;
  endtask

  initial begin
    logic [7:0] d;
    logic [7:0] r [8];
    for (int i = 0; i < DEPTH; i++) bufModel[i] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1", csN, 4'hF, "selects idle");
    chk("R1", sclk, 0, "clock idle");
    rd(8'h4F, d);
    chk("R1", d[7], 0, "busy after reset");

    // R11 buffer window
    wrBuf(69, 8'h5A);
    rd(8'hC5, d);
    chk("R11", d, 8'h5A, "last buffer slot");
    wr(8'hC6, 8'h33);
    rd(8'hC6, d);
    chk("R11", d, 8'h00, "past buffer end");

    // receive-only frame: ID style read
    r = '{8'hEF, 8'h40, 8'h18, 0, 0, 0, 0, 0};
    startFrame(8'h9F, 2, 0, 3, r);
    finishFrame(0, 3, "read-id");

    // address + dummy then receive
    clearPtr();
    wrBuf(0, 8'h12); wrBuf(1, 8'h34); wrBuf(2, 8'h56); wrBuf(3, 8'hFF);
    r = '{8'hDE, 8'hAD, 8'hBE, 8'hEF, 0, 0, 0, 0};
    startFrame(8'h0B, 1, 4, 4, r);
    finishFrame(4, 4, "fast-read");

    // transmit only
    clearPtr();
    wrBuf(0, 8'hC3); wrBuf(1, 8'h3C);
    r = '{default: 8'h00};
    startFrame(8'h02, 0, 2, 0, r);
    finishFrame(2, 0, "write");

    // R9 opcode only
    startFrame(8'h05, 3, 0, 0, r);
    finishFrame(0, 0, "R9 opcode-only");
    rd(8'h82, d);
    chk("R9", d, bufModel[2], "buffer untouched");

    // R10 pointer persists, then clear rewinds
    wrBuf(2, 8'h77);
    startFrame(8'hA1, 0, 1, 0, r);
    finishFrame(1, 0, "R10 no clear");
    clearPtr();
    startFrame(8'hA2, 0, 1, 0, r);
    finishFrame(1, 0, "R10 after clear");

    // R8 writes during busy ignored
    clearPtr();
    r = '{8'h99, 0, 0, 0, 0, 0, 0, 0};
    startFrame(8'hA5, 1, 0, 1, r);
    repeat (5) @(negedge clk);
    wr(8'h45, 8'h11);
    wr(8'h47, 8'h80);
    wr(8'h1D, 8'h03);
    finishFrame(0, 1, "R8 intrusion");
    rd(8'h45, d);
    chk("R8", d, 8'hA5, "opcode kept");
    rd(8'h1D, d);
    chk("R8", d, 8'h01, "select kept");
    repeat (20) @(negedge clk);
    chk("R8", riseCnt, 16, "no second frame");

    done = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; failed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end
endmodule